// File: doc/BRIEF.md
# System Configuration and Remap Register File

This block is a small bank of control registers on a plain 32-bit read/write bus, with a byte enable for each lane. It holds the settings that shape the chip's wiring. One field selects which memory appears at address zero, and that field takes its reset value from the boot strap pins. Three bits pick the DMA channel for three peripheral request sources. Further bits enable the fast-mode-plus pad drive for I2C pads. Four registers pick, for each of 16 external-interrupt lines, the port whose pin feeds that line.

The block drives these outputs straight from the stored settings. It produces a 2-bit alias code and three DMA channel numbers. It gives an effective fast-mode-plus enable for each of six pads, combining the per-pad bits with two per-controller bits. It also carries the 16 selected interrupt source lines. A second configuration register holds two enables that can be set but not cleared, and these route fault signals to a timer break input.

Top module: `sysmap_regfile`

## Requirements
- R1: During reset the alias field (bits 1:0 at offset 0x00) loads `boot_strap`. Every other stored bit resets to zero, so every interrupt line selects port A.
- R2: A write stores only the byte lanes whose `be` bit is 1. A read returns the word on `rdata` one cycle after `rd_en`, and `rdata` is zero in any cycle that follows a cycle without `rd_en`.
- R3: At offset 0x00 only bits 23:16, 12:10 and 1:0 are stored; all other bits read zero and ignore writes. At offsets 0x08 to 0x14, bits 31:16 read zero.
- R4: Offsets other than 0x00, 0x08, 0x0C, 0x10, 0x14 and 0x18 read zero, and writes to them change no register or output.
- R5: `mem_alias` always equals bits 1:0 of the register at offset 0x00.
- R6: Bit 11 at 0x00 routes timer-16 requests to channel 3 (0) or 4 (1). Bit 12 routes timer-17 requests to channel 1 (0) or 2 (1). Bit 10 routes serial-receive requests to channel 3 (0) or 5 (1).
- R7: Line x is set by the 4-bit field at bits 4*(x mod 4)+3 down to 4*(x mod 4) of offset 0x08+4*(x div 4). Codes 0,1,2,3,5 select pin x of ports A,B,C,D,F, which are bits x, 16+x, 32+x, 48+x and 64+x of `port_pins`.
- R8: Any other select code (4, or 6 to 15) drives the line to 0.
- R9: `fmp_en[p]` is the OR of three terms: its pad bit, bit 20 ANDed with `pad_on_c1[p]`, and bit 21 ANDed with `pad_on_c2[p]`. Pads 0 to 3 use bits 16 to 19, and pads 4 and 5 use bits 22 and 23.
- R10: At offset 0x18, writing 1 to bit 0 or bit 1 (lane 0 enabled) sets that bit of `brk_link`, and writing 0 has no effect. Only reset clears these bits, and the other bits read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| boot_strap | input | 2 | Boot-pin strap value for the alias field |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Read request, data registered |
| addr | input | 8 | Byte address of the register |
| wdata | input | 32 | Write data |
| be | input | 4 | Byte-lane enables for writes |
| rdata | output | 32 | Registered read data |
| port_pins | input | 80 | Pins of ports A,B,C,D,F, 16 each, A lowest |
| pad_on_c1 | input | 6 | Pad currently assigned to I2C controller 1 |
| pad_on_c2 | input | 6 | Pad currently assigned to I2C controller 2 |
| mem_alias | output | 2 | Memory alias code at address zero |
| t16_dma_ch | output | 3 | Timer-16 DMA channel number |
| t17_dma_ch | output | 3 | Timer-17 DMA channel number |
| urx_dma_ch | output | 3 | Serial-receive DMA channel number |
| exti_line | output | 16 | Selected interrupt source per line |
| fmp_en | output | 6 | Effective fast-mode-plus enable per pad |
| brk_link | output | 2 | Set-only fault-to-break enables |

## Verification
Two things are hard to reach from the ports. The first is a reserved select code sitting in a field whose neighbours are valid, while the unselected port pins are all high, so that a wrong decode shows as a 1. The second is a pad enabled only through a controller bit combined with an assignment input. The stimulus writes randomly chosen data with partial byte enables to a weighted mix of mapped and unmapped offsets. It redraws all 80 pins and both assignment vectors after every write. Directed steps add the all-reserved codes, the port F code, a second reset under a different strap value, and repeated zero writes to the set-only bits.

// File: rtl/sysmap_pkg.sv
// Shared constants and the port-select decode for the configuration block.
// Assumes word-aligned register offsets; the byte-address LSBs are ignored.
package sysmap_pkg;
    localparam int unsigned DATA_W      = 32;
    localparam int unsigned LINES       = 16;
    localparam int unsigned PORTS       = 5;
    localparam int unsigned PINS        = 16;
    localparam int unsigned SEL_W       = 4;
    localparam int unsigned FMP_PADS    = 6;
    localparam int unsigned PORT_IDX_W  = $clog2(PORTS);

    // Word indices (byte offset / 4) of the mapped registers.
    localparam int unsigned WIDX_CFG1   = 0;
    localparam int unsigned WIDX_SEL0   = 2;
    localparam int unsigned WIDX_CFG2   = 6;

    // Writable bits of the main configuration word.
    localparam logic [31:0] CFG1_WMASK  = 32'h00FF_1C03;
    localparam int unsigned BIT_URX     = 10;
    localparam int unsigned BIT_T16     = 11;
    localparam int unsigned BIT_T17     = 12;
    localparam int unsigned BIT_CTL1    = 20;
    localparam int unsigned BIT_CTL2    = 21;

    typedef struct packed {
        logic                  valid;
        logic [PORT_IDX_W-1:0] idx;
    } port_sel_t;

    // Sparse code to dense port index; reserved codes are flagged invalid.
    function automatic port_sel_t decode_port(input logic [SEL_W-1:0] code);
        port_sel_t r;
        r.valid = 1'b1;
        r.idx   = '0;
        case (code)
            4'd0:    r.idx = PORT_IDX_W'(0);
            4'd1:    r.idx = PORT_IDX_W'(1);
            4'd2:    r.idx = PORT_IDX_W'(2);
            4'd3:    r.idx = PORT_IDX_W'(3);
            4'd5:    r.idx = PORT_IDX_W'(4);
            default: r.valid = 1'b0;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/sysmap_regs.sv
// Register storage and bus access for the configuration block.
// Assumes single-cycle write strobes; read data is registered and is zero
// in cycles that follow no read. Reset is synchronous, active low.
module sysmap_regs
    import sysmap_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned NLINES = LINES
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [1:0]              boot_strap,
    input  logic                    wr_en,
    input  logic                    rd_en,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [DATA_W-1:0]       wdata,
    input  logic [DATA_W/8-1:0]     be,
    output logic [DATA_W-1:0]       rdata,
    output logic [DATA_W-1:0]       cfg1,
    output logic [NLINES*SEL_W-1:0] sel_flat,
    output logic [1:0]              cfg2
);
    localparam int unsigned WIDX_W   = ADDR_W - 2;
    localparam int unsigned SEL_BITS = 16;
    localparam int unsigned SEL_REGS = NLINES * SEL_W / SEL_BITS;
    localparam int unsigned LANES    = DATA_W / 8;

    logic [WIDX_W-1:0] widx;
    logic [DATA_W-1:0] lane_mask;
    logic [DATA_W-1:0] cfg1_merged;
    logic [DATA_W-1:0] rd_val;
    logic              unused_addr_lsb;

    assign widx            = addr[ADDR_W-1:2];
    assign unused_addr_lsb = ^addr[1:0];

    // Expand each byte enable to a full lane of mask bits.
    generate
        for (genvar i = 0; i < LANES; i++) begin : g_lane
            assign lane_mask[8*i +: 8] = {8{be[i]}};
        end
    endgenerate

    // Byte-lane merge of write data into the main configuration word.
    assign cfg1_merged = ((cfg1 & ~lane_mask) | (wdata & lane_mask)) & CFG1_WMASK;

    // Main configuration word: alias field reloads the strap during reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg1 <= {{(DATA_W-2){1'b0}}, boot_strap};
        else if (wr_en && widx == WIDX_W'(WIDX_CFG1))
            cfg1 <= cfg1_merged;
    end

    // Interrupt source select words, four fields each, low half only.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sel_flat <= '0;
        else if (wr_en) begin
            for (int r = 0; r < SEL_REGS; r++) begin
                if (widx == WIDX_W'(WIDX_SEL0 + r))
                    sel_flat[SEL_BITS*r +: SEL_BITS] <=
                        (sel_flat[SEL_BITS*r +: SEL_BITS] & ~lane_mask[SEL_BITS-1:0]) |
                        (wdata[SEL_BITS-1:0] & lane_mask[SEL_BITS-1:0]);
            end
        end
    end

    // Second configuration word: set-only bits, cleared by reset alone.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg2 <= '0;
        else if (wr_en && widx == WIDX_W'(WIDX_CFG2) && be[0])
            cfg2 <= cfg2 | wdata[1:0];
    end

    // Read multiplexer; unmapped offsets return zero.
    always_comb begin
        rd_val = '0;
        if (widx == WIDX_W'(WIDX_CFG1))
            rd_val = cfg1;
        if (widx == WIDX_W'(WIDX_CFG2))
            rd_val = {{(DATA_W-2){1'b0}}, cfg2};
        for (int r = 0; r < SEL_REGS; r++) begin
            if (widx == WIDX_W'(WIDX_SEL0 + r))
                rd_val = {{(DATA_W-SEL_BITS){1'b0}}, sel_flat[SEL_BITS*r +: SEL_BITS]};
        end
    end

    // Registered read data, zero when no read was requested.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata <= '0;
        else
            rdata <= rd_en ? rd_val : '0;
    end
endmodule

// File: rtl/sysmap_exti_mux.sv
// Per-line interrupt source multiplexer. Line x takes pin x of the port
// chosen by its select field; reserved codes give a constant zero.
// Assumes the line count does not exceed the pins per port.
module sysmap_exti_mux
    import sysmap_pkg::*;
#(
    parameter int unsigned NLINES = LINES
) (
    input  logic [NLINES*SEL_W-1:0] sel_flat,
    input  logic [PORTS*PINS-1:0]   port_pins,
    output logic [NLINES-1:0]       exti_line
);
    generate
        for (genvar x = 0; x < NLINES; x++) begin : g_line
            logic [PORTS-1:0] cand;
            port_sel_t        dec;

            for (genvar p = 0; p < PORTS; p++) begin : g_port
                assign cand[p] = port_pins[p*PINS + x];
            end

            assign dec = decode_port(sel_flat[x*SEL_W +: SEL_W]);

            // Pick the selected port's pin or force zero for reserved codes.
            always_comb begin
                exti_line[x] = dec.valid ? cand[dec.idx] : 1'b0;
            end
        end
    endgenerate
endmodule

// File: rtl/sysmap_fmp.sv
// Effective fast-mode-plus enable per pad: the pad's own bit ORed with each
// controller bit gated by that pad's current controller assignment.
module sysmap_fmp #(
    parameter int unsigned NPADS = 6
) (
    input  logic [NPADS-1:0] pad_bits,
    input  logic             ctl1,
    input  logic             ctl2,
    input  logic [NPADS-1:0] on_c1,
    input  logic [NPADS-1:0] on_c2,
    output logic [NPADS-1:0] fmp_en
);
    generate
        for (genvar p = 0; p < NPADS; p++) begin : g_pad
            assign fmp_en[p] = pad_bits[p] | (ctl1 & on_c1[p]) | (ctl2 & on_c2[p]);
        end
    endgenerate
endmodule

// File: rtl/sysmap_regfile.sv
// Top of the system configuration and remap register file. Ties the bus
// register bank to the alias, DMA routing, pad drive and interrupt mux
// outputs. Outputs follow register state in the cycle after a write.
module sysmap_regfile
    import sysmap_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [1:0]             boot_strap,
    input  logic                   wr_en,
    input  logic                   rd_en,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [DATA_W-1:0]      wdata,
    input  logic [DATA_W/8-1:0]    be,
    output logic [DATA_W-1:0]      rdata,
    input  logic [PORTS*PINS-1:0]  port_pins,
    input  logic [FMP_PADS-1:0]    pad_on_c1,
    input  logic [FMP_PADS-1:0]    pad_on_c2,
    output logic [1:0]             mem_alias,
    output logic [2:0]             t16_dma_ch,
    output logic [2:0]             t17_dma_ch,
    output logic [2:0]             urx_dma_ch,
    output logic [LINES-1:0]       exti_line,
    output logic [FMP_PADS-1:0]    fmp_en,
    output logic [1:0]             brk_link
);
    logic [DATA_W-1:0]      cfg1;
    logic [LINES*SEL_W-1:0] sel_flat;
    logic [1:0]             cfg2;
    logic [FMP_PADS-1:0]    pad_bits;
    logic                   unused_cfg1;

    sysmap_regs #(.ADDR_W(ADDR_W), .NLINES(LINES)) u_regs (
        .clk(clk), .rst_n(rst_n), .boot_strap(boot_strap),
        .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata), .be(be),
        .rdata(rdata), .cfg1(cfg1), .sel_flat(sel_flat), .cfg2(cfg2)
    );

    sysmap_exti_mux #(.NLINES(LINES)) u_exti (
        .sel_flat(sel_flat), .port_pins(port_pins), .exti_line(exti_line)
    );

    // Pads 0..3 use bits 19:16, pads 4..5 use bits 23:22.
    assign pad_bits = {cfg1[23:22], cfg1[19:16]};

    sysmap_fmp #(.NPADS(FMP_PADS)) u_fmp (
        .pad_bits(pad_bits), .ctl1(cfg1[BIT_CTL1]), .ctl2(cfg1[BIT_CTL2]),
        .on_c1(pad_on_c1), .on_c2(pad_on_c2), .fmp_en(fmp_en)
    );

    // Alias code and DMA channel numbers straight from stored bits.
    assign mem_alias  = cfg1[1:0];
    assign t16_dma_ch = cfg1[BIT_T16] ? 3'd4 : 3'd3;
    assign t17_dma_ch = cfg1[BIT_T17] ? 3'd2 : 3'd1;
    assign urx_dma_ch = cfg1[BIT_URX] ? 3'd5 : 3'd3;
    assign brk_link   = cfg2;

    assign unused_cfg1 = ^{cfg1[31:24], cfg1[15:13], cfg1[9:2]};
endmodule

// File: rtl/sysmap_chk.sv
// Assertion checker for sysmap_regfile, attached by bind below.
module sysmap_chk
    import sysmap_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   wr_en,
    input logic                   rd_en,
    input logic [ADDR_W-1:0]      addr,
    input logic [DATA_W/8-1:0]    be,
    input logic [DATA_W-1:0]      rdata,
    input logic [1:0]             mem_alias,
    input logic [2:0]             t16_dma_ch,
    input logic [2:0]             t17_dma_ch,
    input logic [2:0]             urx_dma_ch,
    input logic [LINES-1:0]       exti_line,
    input logic [LINES*SEL_W-1:0] sel_flat,
    input logic [DATA_W-1:0]      cfg1,
    input logic [FMP_PADS-1:0]    fmp_en,
    input logic [1:0]             brk_link
);
    localparam int unsigned WIDX_W = ADDR_W - 2;
    logic [WIDX_W-1:0] widx;
    logic              mapped;
    logic              alias_wr;
    assign widx     = addr[ADDR_W-1:2];
    assign mapped   = (widx == WIDX_W'(WIDX_CFG1)) || (widx == WIDX_W'(WIDX_CFG2)) ||
                      (widx >= WIDX_W'(WIDX_SEL0) && widx < WIDX_W'(WIDX_SEL0 + LINES/4));
    assign alias_wr = wr_en && widx == WIDX_W'(WIDX_CFG1) && be[0];

    // R5
    alias_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(alias_wr) |-> $stable(mem_alias));

    // R2
    rdata_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rd_en) |-> rdata == '0);

    // R4
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rd_en) && !$past(mapped)) |-> rdata == '0);

    // R6
    dma_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (t16_dma_ch inside {3'd3, 3'd4}) && (t17_dma_ch inside {3'd1, 3'd2}) &&
        (urx_dma_ch inside {3'd3, 3'd5}));

    // R9
    fmp_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ({cfg1[23:22], cfg1[19:16]} & ~fmp_en) == '0);

    generate
        for (genvar x = 0; x < LINES; x++) begin : g_rsv
            // R8
            exti_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
                !(sel_flat[x*SEL_W +: SEL_W] inside {4'd0, 4'd1, 4'd2, 4'd3, 4'd5})
                |-> !exti_line[x]);
        end
        for (genvar b = 0; b < 2; b++) begin : g_brk
            // R10
            brk_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $past(brk_link[b]) |-> brk_link[b]);
        end
    endgenerate
endmodule

bind sysmap_regfile sysmap_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .be(be),
    .rdata(rdata), .mem_alias(mem_alias), .t16_dma_ch(t16_dma_ch),
    .t17_dma_ch(t17_dma_ch), .urx_dma_ch(urx_dma_ch), .exti_line(exti_line),
    .sel_flat(sel_flat), .cfg1(cfg1), .fmp_en(fmp_en), .brk_link(brk_link)
);

// File: tb/tb_sysmap_regfile.sv
module tb_sysmap_regfile;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  boot_strap = 2'b10;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [3:0]  be = '0;
    logic [31:0] rdata;
    logic [79:0] port_pins = '0;
    logic [5:0]  pad_on_c1 = '0, pad_on_c2 = '0;
    logic [1:0]  mem_alias, brk_link;
    logic [2:0]  t16_dma_ch, t17_dma_ch, urx_dma_ch;
    logic [15:0] exti_line;
    logic [5:0]  fmp_en;

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    logic [31:0] m_cfg1;
    logic [15:0] m_sel [4];
    logic [1:0]  m_cfg2;

    always #5 clk = ~clk;

    sysmap_regfile dut (.*);

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_cfg1 = {30'b0, boot_strap};
        for (int i = 0; i < 4; i++) m_sel[i] = '0;
        m_cfg2 = '0;
    endtask

    task automatic do_reset(logic [1:0] strap);
        @(negedge clk);
        boot_strap = strap; rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
    endtask

    task automatic bus_write(logic [7:0] a, logic [31:0] d, logic [3:0] b);
        logic [31:0] m;
        logic [5:0]  w;
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d; be = b;
        @(negedge clk);
        wr_en = 1'b0;
        m = {{8{b[3]}}, {8{b[2]}}, {8{b[1]}}, {8{b[0]}}};
        w = a[7:2];
        case (w)
            6'd0: m_cfg1 = ((m_cfg1 & ~m) | (d & m)) & 32'h00FF_1C03;
            6'd2, 6'd3, 6'd4, 6'd5:
                m_sel[w-2] = (m_sel[w-2] & ~m[15:0]) | (d[15:0] & m[15:0]);
            6'd6: if (b[0]) m_cfg2 = m_cfg2 | d[1:0];
            default: ;
        endcase
    endtask

    function automatic logic [31:0] exp_read(logic [7:0] a);
        case (a[7:2])
            6'd0: return m_cfg1;
            6'd2, 6'd3, 6'd4, 6'd5: return {16'b0, m_sel[a[7:2]-2]};
            6'd6: return {30'b0, m_cfg2};
            default: return '0;
        endcase
    endfunction

    task automatic bus_read_chk(string req, logic [7:0] a);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        chk(req, rdata, exp_read(a));
        rd_en = 1'b0;
    endtask

    function automatic logic exp_line(int x);
        logic [3:0] c = m_sel[x/4][4*(x%4) +: 4];
        case (c)
            4'd0: return port_pins[x];
            4'd1: return port_pins[16+x];
            4'd2: return port_pins[32+x];
            4'd3: return port_pins[48+x];
            4'd5: return port_pins[64+x];
            default: return 1'b0;
        endcase
    endfunction

    task automatic check_outputs(string req_line, string req_fmp);
        logic [15:0] el;
        logic [5:0]  ef;
        #1;
        for (int x = 0; x < 16; x++) el[x] = exp_line(x);
        ef = {m_cfg1[23:22], m_cfg1[19:16]} | ({6{m_cfg1[20]}} & pad_on_c1) |
             ({6{m_cfg1[21]}} & pad_on_c2);
        chk("R5 alias", {30'b0, mem_alias}, {30'b0, m_cfg1[1:0]});
        chk("R6 dma", {20'b0, t16_dma_ch, t17_dma_ch, urx_dma_ch},
            {20'b0, m_cfg1[11] ? 3'd4 : 3'd3, m_cfg1[12] ? 3'd2 : 3'd1, m_cfg1[10] ? 3'd5 : 3'd3});
        chk(req_line, {16'b0, exti_line}, {16'b0, el});
        chk(req_fmp, {26'b0, fmp_en}, {26'b0, ef});
        chk("R10 brk", {30'b0, brk_link}, {30'b0, m_cfg2});
    endtask

    task automatic rand_pins();
        port_pins = {$urandom(), $urandom(), $urandom()};
        pad_on_c1 = 6'($urandom());
        pad_on_c2 = 6'($urandom());
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] offs [9] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h18, 8'h1C, 8'h40};
        void'($urandom(32'd4242));
        do_reset(2'b10);
        // R1 reset state with strap 2
        chk("R1 alias from strap", {30'b0, mem_alias}, 32'd2);
        bus_read_chk("R1 cfg1 reset", 8'h00);
        bus_read_chk("R1 sel reset", 8'h08);
        port_pins = {64'h0, 16'hA5C3};
        check_outputs("R1 port A default", "R9 fmp reset");
        // R2 rdata idle after read
        @(negedge clk);
        chk("R2 rdata idle", rdata, 32'h0);

        // R3 reserved bits of cfg1; R5 alias; R6 routing
        bus_write(8'h00, 32'hFFFF_FFFF, 4'hF);
        bus_read_chk("R3 cfg1 mask", 8'h00);
        chk("R6 t16 ch4", {29'b0, t16_dma_ch}, 32'd4);
        chk("R6 t17 ch2", {29'b0, t17_dma_ch}, 32'd2);
        chk("R6 urx ch5", {29'b0, urx_dma_ch}, 32'd5);
        check_outputs("R7 lines", "R9 fmp all");
        bus_write(8'h00, 32'h0000_0001, 4'hF);
        check_outputs("R7 lines", "R9 fmp none");
        chk("R5 alias 1", {30'b0, mem_alias}, 32'd1);

        // R2 byte lanes, R3 upper half of select regs
        bus_write(8'h08, 32'hAAAA_5555, 4'b0001);
        bus_read_chk("R2 byte lane", 8'h08);
        bus_write(8'h0C, 32'hFFFF_1234, 4'b1110);
        bus_read_chk("R3 sel upper zero", 8'h0C);

        // R4 unmapped offsets
        bus_write(8'h04, 32'hFFFF_FFFF, 4'hF);
        bus_write(8'h1C, 32'hFFFF_FFFF, 4'hF);
        bus_write(8'h40, 32'hFFFF_FFFF, 4'hF);
        bus_read_chk("R4 unmapped 04", 8'h04);
        bus_read_chk("R4 unmapped 1C", 8'h1C);
        bus_read_chk("R4 cfg1 untouched", 8'h00);
        check_outputs("R4 lines untouched", "R4 fmp untouched");

        // R8 reserved codes with all pins high; R7 port F
        port_pins = '1;
        bus_write(8'h08, 32'h0000_F6E4, 4'hF);
        bus_write(8'h10, 32'h0000_5555, 4'hF);
        check_outputs("R8 reserved codes", "R9 fmp");
        port_pins = {16'hBEEF, 64'h0};
        check_outputs("R7 port F", "R9 fmp");

        // R9 controller bits only
        bus_write(8'h00, 32'h0010_0000, 4'hF);
        pad_on_c1 = 6'b001010; pad_on_c2 = 6'b110000;
        check_outputs("R7 lines", "R9 ctl1 gated");
        chk("R9 ctl1 pads", {26'b0, fmp_en}, 32'b001010);

        // R10 set-only bits
        bus_write(8'h18, 32'hFFFF_FFFD, 4'hF);
        bus_write(8'h18, 32'h0, 4'hF);
        bus_write(8'h18, 32'h2, 4'b1110);
        bus_read_chk("R10 sticky", 8'h18);
        bus_write(8'h18, 32'h2, 4'b0001);
        chk("R10 both set", {30'b0, brk_link}, 32'd3);

        // R1 second reset with another strap
        do_reset(2'b01);
        chk("R1 alias strap 1", {30'b0, mem_alias}, 32'd1);
        chk("R1 brk cleared", {30'b0, brk_link}, 32'd0);
        bus_read_chk("R1 cfg1 after reset", 8'h00);

        // Random mix
        for (int it = 0; it < 400; it++) begin
            logic [7:0] a = offs[$urandom_range(0, 8)];
            bus_write(a, $urandom(), 4'($urandom()));
            rand_pins();
            check_outputs("R7 random lines", "R9 random fmp");
            if (it % 3 == 0) bus_read_chk("R2 random read", offs[$urandom_range(0, 8)]);
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule